// File: doc/BRIEF.md
# Downstream bus flush sequencer

This block clears a downstream two-wire bus before a new controller is attached to it. Once started, it takes the open-drain clock and data lines and sends a burst of clock pulses with data released. A target that was left part-way through a read therefore shifts out the rest of its byte and sees a not-acknowledge. The block then forms a STOP condition, releases both lines and raises a one-cycle done pulse, so that the connection logic around it can attach the new controller.

Every half-period of the sequence lasts until the next `tick_i` pulse from an external clock divider. With a divider that ticks every 5 µs, the pulses run at about 100 kHz. The outputs are active-high drive-low enables: a 1 pulls the line low and a 0 releases it. The sequence is always the same and does not depend on what the lines were doing before.

Top module: `bus_flush_seq`

## Requirements
- R1: After reset, and whenever no sequence is running, `busy_o`, `done_o`, `scl_low_o` and `sda_low_o` are all 0, so both lines are released.
- R2: A `start_i` sampled high while idle makes `busy_o` and `scl_low_o` go to 1 on the next cycle, with `sda_low_o` at 0. A `tick_i` in that same cycle does not shorten the first phase.
- R3: Each sequence drives exactly `NUM_PULSES` (default 9) clock pulses. A pulse is a low half-period followed by a released half-period, and `sda_low_o` is 0 for the whole burst.
- R4: A phase ends only at a cycle in which `tick_i` is 1, and the new line state appears on the following cycle. Without a tick, the outputs hold.
- R5: After the last pulse, the STOP is formed in three half-periods: SCL low with SDA released, then SCL low with SDA low, then SCL released with SDA low. SDA never starts being driven low while SCL is released.
- R6: The tick that ends the STOP hold releases SDA. On the next cycle `done_o` is 1 for exactly one cycle, and `busy_o` is 0 in that same cycle.
- R7: A `start_i` received while `busy_o` is 1 is ignored. The sequence in progress continues unchanged.
- R8: While idle, `tick_i` has no effect on any output. A `start_i` in the done cycle begins a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to run the flush sequence |
| tick_i | input | 1 | Half-period tick from the clock divider |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the sequence ends |
| scl_low_o | output | 1 | Drive downstream SCL low |
| sda_low_o | output | 1 | Drive downstream SDA low |

## Verification
The properties assume that `tick_i` and `start_i` change only between clock edges and that reset is applied before the first sequence. They make no other assumption about tick spacing: a tick may arrive on every cycle or after long gaps, and a start may arrive during a run. The stimulus drives both inputs on the falling edge. It uses a tick on every cycle, a fixed divide-by-five pattern and a pseudo-random pattern, and it adds starts that arrive mid-run, at the same time as a tick, and held through a done cycle.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CLK_LO,
    PH_CLK_HI,
    PH_STOP_PRE,
    PH_STOP_LOW,
    PH_STOP_HOLD
  } phase_e;
endpackage

// File: rtl/bfs_pulse_cnt.sv
module bfs_pulse_cnt #(
  parameter int NUM_PULSES = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = $clog2(NUM_PULSES + 1);
  localparam logic [CW-1:0] LAST = CW'(NUM_PULSES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  // current high phase belongs to the final pulse
  assign last_o = (cnt_q == LAST);
endmodule

// File: rtl/bfs_phase_fsm.sv
module bfs_phase_fsm
  import bfs_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   tick_i,
  input  logic   last_i,
  output phase_e state_d_o,
  output logic   clr_o,
  output logic   inc_o,
  output logic   done_o
);
  phase_e state_q, state_d;
  logic   fin;
  logic   done_q;

  always_comb begin
    state_d = state_q;
    clr_o   = 1'b0;
    inc_o   = 1'b0;
    fin     = 1'b0;
    unique case (state_q)
      PH_IDLE: if (start_i) begin
        state_d = PH_CLK_LO;
        clr_o   = 1'b1;
      end
      PH_CLK_LO:   if (tick_i) state_d = PH_CLK_HI;
      PH_CLK_HI:   if (tick_i) begin
        inc_o   = 1'b1;
        state_d = last_i ? PH_STOP_PRE : PH_CLK_LO;
      end
      PH_STOP_PRE:  if (tick_i) state_d = PH_STOP_LOW;
      PH_STOP_LOW:  if (tick_i) state_d = PH_STOP_HOLD;
      PH_STOP_HOLD: if (tick_i) begin
        state_d = PH_IDLE;
        fin     = 1'b1;
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
    end
  end

  assign state_d_o = state_d;
  assign done_o    = done_q;
endmodule

// File: rtl/bfs_line_drv.sv
module bfs_line_drv
  import bfs_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  phase_e state_d_i,
  output logic   busy_o,
  output logic   scl_low_o,
  output logic   sda_low_o
);
  logic scl_d, sda_d;

  always_comb begin
    scl_d = 1'b0;
    sda_d = 1'b0;
    unique case (state_d_i)
      PH_CLK_LO:    scl_d = 1'b1;
      PH_STOP_PRE:  scl_d = 1'b1;
      PH_STOP_LOW:  begin scl_d = 1'b1; sda_d = 1'b1; end
      PH_STOP_HOLD: sda_d = 1'b1;
      default: ;
    endcase
  end

  // registered so the open-drain enables never glitch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o    <= 1'b0;
      scl_low_o <= 1'b0;
      sda_low_o <= 1'b0;
    end else begin
      busy_o    <= (state_d_i != PH_IDLE);
      scl_low_o <= scl_d;
      sda_low_o <= sda_d;
    end
  end
endmodule

// File: rtl/bus_flush_seq.sv
module bus_flush_seq
  import bfs_pkg::*;
#(
  parameter int NUM_PULSES = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  output logic busy_o,
  output logic done_o,
  output logic scl_low_o,
  output logic sda_low_o
);
  phase_e state_d;
  logic   clr, inc, last;

  bfs_pulse_cnt #(.NUM_PULSES(NUM_PULSES)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .inc_i  (inc),
    .last_o (last)
  );

  bfs_phase_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .tick_i    (tick_i),
    .last_i    (last),
    .state_d_o (state_d),
    .clr_o     (clr),
    .inc_o     (inc),
    .done_o    (done_o)
  );

  bfs_line_drv u_drv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_d_i (state_d),
    .busy_o    (busy_o),
    .scl_low_o (scl_low_o),
    .sda_low_o (sda_low_o)
  );
endmodule

// File: rtl/bfs_checker.sv
module bfs_checker #(
  parameter int NUM_PULSES = 9
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic tick_i,
  input logic busy_o,
  input logic done_o,
  input logic scl_low_o,
  input logic sda_low_o
);
  localparam int RW = $clog2(NUM_PULSES + 2);

  logic [RW-1:0] rel_q;
  logic          scl_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_q      <= '0;
      scl_prev_q <= 1'b0;
    end else begin
      scl_prev_q <= scl_low_o;
      if (!busy_o) rel_q <= '0;
      else if (scl_prev_q && !scl_low_o && !sda_low_o) rel_q <= rel_q + 1'b1;
    end
  end

  p_idle_released_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!scl_low_o && !sda_low_o));

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && scl_low_o && !sda_low_o));

  p_pulse_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rel_q == RW'(NUM_PULSES)));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> (busy_o && $stable(scl_low_o) && $stable(sda_low_o)));

  p_sda_under_low_scl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_low_o) |-> (scl_low_o && $past(scl_low_o)));

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !scl_low_o && !sda_low_o && $past(busy_o) && $past(tick_i)));

  p_done_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_idle_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> (!busy_o && !done_o && !scl_low_o && !sda_low_o));
endmodule

bind bus_flush_seq bfs_checker #(.NUM_PULSES(NUM_PULSES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .tick_i    (tick_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .scl_low_o (scl_low_o),
  .sda_low_o (sda_low_o)
);

// File: tb/bus_flush_seq_tb.sv
module bus_flush_seq_tb;
  localparam int NP      = 9;
  localparam int LAST_HP = 2 * NP + 2;
  localparam int WD      = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic tick = 1'b0;
  logic busy, done, scl_low, sda_low;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int tick_mode = 0;
  int div_cnt = 0;
  logic [7:0] lfsr = 8'hA5;

  int m_hp = -1;
  logic m_done = 1'b0;

  int pulses = 0;
  int last_pulses = 0;
  logic scl_prev = 1'b0;

  always #5 clk = ~clk;

  bus_flush_seq #(.NUM_PULSES(NP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tick_i(tick),
    .busy_o(busy), .done_o(done), .scl_low_o(scl_low), .sda_low_o(sda_low)
  );

  // reference model: half-period index, -1 when idle
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hp   <= -1;
      m_done <= 1'b0;
    end else begin
      m_done <= 1'b0;
      if (m_hp < 0) begin
        if (start) m_hp <= 0;
      end else if (tick) begin
        if (m_hp == LAST_HP) begin
          m_hp   <= -1;
          m_done <= 1'b1;
        end else m_hp <= m_hp + 1;
      end
    end
  end

  function automatic logic exp_scl(int hp);
    if (hp < 0) return 1'b0;
    if (hp < 2 * NP) return (hp % 2) == 0;
    return (hp == 2 * NP) || (hp == 2 * NP + 1);
  endfunction

  function automatic logic exp_sda(int hp);
    return (hp == 2 * NP + 1) || (hp == 2 * NP + 2);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // cycle compare and pulse counting
  always @(negedge clk) begin
    if (rst_n) begin
      string lreq;
      lreq = (m_hp >= 2 * NP) ? "R5" : (m_hp == 0 ? "R2" : "R4");
      check(m_hp < 0 ? "R1" : "R2", "busy", busy, (m_hp >= 0));
      check(lreq, "scl_low", scl_low, exp_scl(m_hp));
      check(lreq, "sda_low", sda_low, exp_sda(m_hp));
      check("R6", "done", done, m_done);
      if (busy && scl_prev && !scl_low && !sda_low) pulses++;
      if (busy && !scl_low && sda_low && scl_prev == 1'b0 && m_hp < 2 * NP)
        check("R3", "sda during burst", 1, 0);
      if (done) begin
        check("R3", "pulses per run", pulses, NP);
        last_pulses = pulses;
        pulses = 0;
      end
      scl_prev = scl_low;
    end
  end

  // tick generator
  always @(negedge clk) begin
    case (tick_mode)
      0: tick <= 1'b1;
      1: begin
        div_cnt = (div_cnt == 4) ? 0 : div_cnt + 1;
        tick <= (div_cnt == 0);
      end
      2: begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tick <= lfsr[0];
      end
      default: tick <= 1'b0;
    endcase
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=<%0d cycles", cyc, WD);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(string req);
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(req, "sequence finished", (n < 5000), 1);
    @(negedge clk);
  endtask

  initial begin
    tick_mode = 3;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "reset busy", busy, 0);
    check("R1", "reset done", done, 0);
    check("R1", "reset scl", scl_low, 0);
    check("R1", "reset sda", sda_low, 0);
    rst_n = 1'b1;
    // R8: ticks while idle change nothing
    tick_mode = 0;
    repeat (10) @(negedge clk);
    check("R8", "idle busy after ticks", busy, 0);

    // tick every cycle, start coincides with tick (R2)
    pulse_start();
    wait_done("R3");

    // divide-by-five ticks
    tick_mode = 1;
    pulse_start();
    repeat (7) @(negedge clk);
    check("R4", "still busy mid-run", busy, 1);
    wait_done("R5");

    // pseudo-random ticks with starts during the run (R7)
    tick_mode = 2;
    pulse_start();
    repeat (5) pulse_start();
    repeat (3) @(negedge clk);
    pulse_start();
    wait_done("R7");
    check("R7", "pulses with mid-run starts", last_pulses, NP);

    // start held across the done cycle restarts at once (R8)
    tick_mode = 0;
    @(negedge clk) start = 1'b1;
    wait_done("R8");
    check("R8", "restart in done cycle busy", busy, 1);
    @(negedge clk) start = 1'b0;
    wait_done("R6");
    repeat (5) @(negedge clk);
    check("R6", "idle after run", busy, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule